// File: doc/BRIEF.md
# Mailbox Request Dispatcher

This block decides what happens to a request object once software has finished writing it into a mailbox and issues a go command. It looks at the first header dword and compares it with a fixed discovery header. If that fails, it compares it with a table of protocol headers set by parameter. It also checks that the number of dwords actually written matches the length declared in the second header dword. A request that passes both checks is handed to one handler through a one-hot select and a start pulse. Any other request is dropped by pulsing a buffer-clear output. No error is raised when a request is dropped.

While a handler runs, the block stays busy and ignores further go commands. When the handler reports completion, the block pulses ready-set if the handler succeeded, or buffer-clear if it failed. If the mailbox error flag is already set when go arrives, the go is ignored entirely. The handlers themselves and the mailbox storage sit outside this block.

Top module: `mbx_dispatch`

## Requirements
- R1: After reset, `busy_o`, `start_o`, `clr_o`, `rdy_set_o` are 0 and `sel_o` is all zeros.
- R2: A go that is accepted produces its result on the outputs in the cycle after the clock edge that samples `go_i`. A dispatch makes `start_o` high for exactly one cycle and sets exactly one bit of `sel_o`.
- R3: A `hdr0_i` equal to the discovery header `{8'h00, DISC_TYPE, DISC_VENDOR}` (default 32'h0000_0001) selects `sel_o` bit 0. This check takes precedence over the table.
- R4: A protocol header is built as `{8'h00, type, vendor}`, with the type in bits [23:16] and the vendor in bits [15:0]. A match with table entry i selects `sel_o` bit i+1. When several entries match, the lowest index wins. The default table is 0x00021E98, 0x00031E98, 0x00031E98.
- R5: The declared length is taken from `hdr1_i[17:0]` only. Bits [31:18] have no effect.
- R6: A declared length field of 0 means 2^18 dwords.
- R7: When the header matches but `wr_cnt_i` is not equal to the declared length, the block pulses `clr_o` for one cycle. `start_o` and `rdy_set_o` stay low.
- R8: A `hdr0_i` that matches neither the discovery header nor any table entry causes a one-cycle `clr_o` pulse and no start.
- R9: When `err_i` is high, a go produces no start, clear or ready-set, and `busy_o` stays low.
- R10: `busy_o` goes high in the cycle that `start_o` is high. It stays high, with `sel_o` held, until the cycle after `hnd_done_i` is sampled. Any go that arrives while busy has no effect.
- R11: When the handler completes with `hnd_ok_i` high, `rdy_set_o` pulses for one cycle. When it completes with `hnd_ok_i` low, `clr_o` pulses instead. In both cases `busy_o` falls and `sel_o` clears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Go command pulse |
| err_i | input | 1 | Mailbox error status flag |
| wr_cnt_i | input | LEN_BITS+1 | Dwords written into the request buffer |
| hdr0_i | input | 32 | Request header dword 0 (vendor and type) |
| hdr1_i | input | 32 | Request header dword 1 (length) |
| hnd_done_i | input | 1 | Handler completion pulse |
| hnd_ok_i | input | 1 | Handler success, valid with done |
| sel_o | output | NUM_PROTO+1 | One-hot handler select (bit 0 = discovery) |
| start_o | output | 1 | Handler start pulse |
| clr_o | output | 1 | Clear both buffers and their counters |
| rdy_set_o | output | 1 | Set data-object-ready status |
| busy_o | output | 1 | A dispatched request is in progress |

## Verification
The hardest case to reach is the maximum-length object. Its length field is zero, so a dispatch requires a write count of exactly 2^18. A random count would almost never hit that value, so the stimulus generator deliberately pairs zero length fields with counts of exactly 2^18 and 2^18-1. The duplicate table entry needs the same kind of steering, and so do go pulses that land while a handler is busy. For these, a share of the headers is drawn from the table, and extra go pulses are inserted during the handler wait.

// File: rtl/mbx_dispatch_pkg.sv
package mbx_dispatch_pkg;

    function automatic logic [31:0] mk_hdr(input logic [15:0] vendor, input logic [7:0] typ);
        return {8'h00, typ, vendor};
    endfunction

    typedef struct packed {
        logic busy;
        logic start;
        logic clr;
        logic rdy;
    } ctl_t;

endpackage

// File: rtl/mbx_hdr_match.sv
module mbx_hdr_match #(
    parameter int NUM_PROTO = 3,
    parameter logic [31:0] DISC_HDR = 32'h0000_0001,
    parameter logic [NUM_PROTO-1:0][31:0] PROTO_HDRS = '0
) (
    input  logic [31:0]          hdr0_i,
    output logic                 hit_o,
    output logic [NUM_PROTO:0]   sel_o
);
    logic [NUM_PROTO-1:0] eq;

    for (genvar g = 0; g < NUM_PROTO; g++) begin : g_cmp
        assign eq[g] = (hdr0_i == PROTO_HDRS[g]);
    end

    always_comb begin
        sel_o = '0;
        if (hdr0_i == DISC_HDR) begin
            sel_o[0] = 1'b1;
        end else begin
            for (int i = NUM_PROTO - 1; i >= 0; i--) begin
                if (eq[i]) begin
                    sel_o    = '0;
                    sel_o[i+1] = 1'b1;
                end
            end
        end
        hit_o = |sel_o;
    end
endmodule

// File: rtl/mbx_len_check.sv
module mbx_len_check #(
    parameter int LEN_BITS = 18
) (
    input  logic [31:0]        hdr1_i,
    input  logic [LEN_BITS:0]  wr_cnt_i,
    output logic               ok_o
);
    localparam logic [LEN_BITS:0] MAX_LEN = {1'b1, {LEN_BITS{1'b0}}};

    logic [LEN_BITS-1:0] fld;
    logic [LEN_BITS:0]   decoded;

    always_comb begin
        fld     = hdr1_i[LEN_BITS-1:0];
        decoded = (fld == '0) ? MAX_LEN : {1'b0, fld};
        ok_o    = (wr_cnt_i == decoded);
    end
endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
    import mbx_dispatch_pkg::*;
#(
    parameter int NUM_PROTO = 3,
    parameter int LEN_BITS  = 18,
    parameter logic [15:0] DISC_VENDOR = 16'h0001,
    parameter logic [7:0]  DISC_TYPE   = 8'h00,
    parameter logic [NUM_PROTO-1:0][31:0] PROTO_HDRS =
        {32'h0003_1E98, 32'h0003_1E98, 32'h0002_1E98}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 err_i,
    input  logic [LEN_BITS:0]    wr_cnt_i,
    input  logic [31:0]          hdr0_i,
    input  logic [31:0]          hdr1_i,
    input  logic                 hnd_done_i,
    input  logic                 hnd_ok_i,
    output logic [NUM_PROTO:0]   sel_o,
    output logic                 start_o,
    output logic                 clr_o,
    output logic                 rdy_set_o,
    output logic                 busy_o
);
    localparam int SEL_W = NUM_PROTO + 1;
    localparam logic [31:0] DISC_HDR = mk_hdr(DISC_VENDOR, DISC_TYPE);

    typedef struct packed {
        ctl_t             ctl;
        logic [SEL_W-1:0] sel;
    } st_t;

    st_t st_d, st_q;
    logic             hit;
    logic [SEL_W-1:0] msel;
    logic             len_ok;

    mbx_hdr_match #(
        .NUM_PROTO (NUM_PROTO),
        .DISC_HDR  (DISC_HDR),
        .PROTO_HDRS(PROTO_HDRS)
    ) u_match (
        .hdr0_i(hdr0_i),
        .hit_o (hit),
        .sel_o (msel)
    );

    mbx_len_check #(.LEN_BITS(LEN_BITS)) u_len (
        .hdr1_i  (hdr1_i),
        .wr_cnt_i(wr_cnt_i),
        .ok_o    (len_ok)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ctl.start = 1'b0;
        st_d.ctl.clr   = 1'b0;
        st_d.ctl.rdy   = 1'b0;
        if (st_q.ctl.busy) begin
            if (hnd_done_i) begin
                st_d.ctl.busy = 1'b0;
                st_d.sel      = '0;
                if (hnd_ok_i) st_d.ctl.rdy = 1'b1;
                else          st_d.ctl.clr = 1'b1;
            end
        end else if (go_i && !err_i) begin
            if (hit && len_ok) begin
                st_d.ctl.busy  = 1'b1;
                st_d.ctl.start = 1'b1;
                st_d.sel       = msel;
            end else begin
                st_d.ctl.clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o     = st_q.sel;
    assign start_o   = st_q.ctl.start;
    assign clr_o     = st_q.ctl.clr;
    assign rdy_set_o = st_q.ctl.rdy;
    assign busy_o    = st_q.ctl.busy;
endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk #(
    parameter int NUM_PROTO = 3,
    parameter int LEN_BITS  = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 go_i,
    input logic                 err_i,
    input logic                 hnd_done_i,
    input logic                 hnd_ok_i,
    input logic [NUM_PROTO:0]   sel_o,
    input logic                 start_o,
    input logic                 clr_o,
    input logic                 rdy_set_o,
    input logic                 busy_o
);
    // R2: a start carries exactly one select bit
    a_r2_onehot_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($countones(sel_o) == 1));

    // R2: start lasts one cycle
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R9: go with error set while idle does nothing
    a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && err_i && !busy_o) |=> (!start_o && !clr_o && !busy_o));

    // R10: go while busy and no completion leaves state held
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !hnd_done_i) |=> (busy_o && !start_o && !clr_o && $stable(sel_o)));

    // R10: start only appears together with busy
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    // R11: success completion
    a_r11_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hnd_done_i && hnd_ok_i) |=> (rdy_set_o && !busy_o && !clr_o));

    // R11: failure completion
    a_r11_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hnd_done_i && !hnd_ok_i) |=> (clr_o && !busy_o && !rdy_set_o));

    // R7: clear and start never coincide
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_o && (start_o || rdy_set_o)));
endmodule

bind mbx_dispatch mbx_dispatch_chk #(
    .NUM_PROTO(NUM_PROTO),
    .LEN_BITS (LEN_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .err_i     (err_i),
    .hnd_done_i(hnd_done_i),
    .hnd_ok_i  (hnd_ok_i),
    .sel_o     (sel_o),
    .start_o   (start_o),
    .clr_o     (clr_o),
    .rdy_set_o (rdy_set_o),
    .busy_o    (busy_o)
);

// File: tb/tb_mbx_dispatch.sv
module tb_mbx_dispatch;
    localparam int NP = 3;
    localparam int LB = 18;
    localparam logic [31:0] DISC = 32'h0000_0001;
    localparam logic [31:0] T0 = 32'h0002_1E98;
    localparam logic [31:0] T1 = 32'h0003_1E98;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, err = 1'b0, done = 1'b0, ok = 1'b0;
    logic [LB:0] cnt = '0;
    logic [31:0] h0 = '0, h1 = '0;
    logic [NP:0] sel;
    logic start, clr, rdy, busy;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    mbx_dispatch dut (
        .clk(clk), .rst_n(rst_n), .go_i(go), .err_i(err), .wr_cnt_i(cnt),
        .hdr0_i(h0), .hdr1_i(h1), .hnd_done_i(done), .hnd_ok_i(ok),
        .sel_o(sel), .start_o(start), .clr_o(clr), .rdy_set_o(rdy), .busy_o(busy)
    );

    function automatic logic [NP:0] exp_sel(input logic [31:0] h);
        if (h == DISC) return 4'b0001;
        if (h == T0)   return 4'b0010;
        if (h == T1)   return 4'b0100;   // entry 2 duplicates entry 1; lower wins
        return 4'b0000;
    endfunction

    function automatic logic [LB:0] exp_len(input logic [31:0] h);
        return (h[LB-1:0] == '0) ? (1 << LB) : {1'b0, h[LB-1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one go at a negedge; sample the result at the following negedge.
    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [LB:0] c, input logic e, input string req);
        logic [NP:0] es;
        logic disp;
        @(negedge clk);
        h0 = a; h1 = b; cnt = c; err = e; go = 1'b1;
        @(negedge clk);
        go = 1'b0; err = 1'b0;
        es   = exp_sel(a);
        disp = !e && (es != '0) && (c == exp_len(b));
        chk({req, " start"}, {31'b0, start}, {31'b0, disp});
        chk({req, " sel"}, {28'b0, sel}, disp ? {28'b0, es} : 32'h0);
        chk({req, " clr"}, {31'b0, clr}, {31'b0, !e && !disp});
        chk({req, " busy"}, {31'b0, busy}, {31'b0, disp});
        if (disp) begin
            int w = $urandom_range(0, 4);
            for (int k = 0; k < w; k++) begin
                @(negedge clk);
                go = 1'b1; h0 = DISC; h1 = 32'h2; cnt = 2;
                @(negedge clk);
                go = 1'b0;
                chk("R10 go ignored while busy", {27'b0, busy, start, clr, rdy, 1'b0}, {27'b0, 5'b10000});
                chk("R10 sel held", {28'b0, sel}, {28'b0, es});
            end
            @(negedge clk);
            done = 1'b1; ok = $urandom_range(0, 1);
            @(negedge clk);
            done = 1'b0;
            chk("R11 ready-set", {31'b0, rdy}, {31'b0, ok});
            chk("R11 clear on fail", {31'b0, clr}, {31'b0, !ok});
            chk("R11 busy drop", {27'b0, busy, sel}, 32'h0);
        end
    endtask

    initial begin : watchdog
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 reset", {27'b0, busy, start, clr, rdy, |sel}, 32'h0);
        rst_n = 1'b1;

        issue(DISC, 32'h2, 2, 1'b0, "R3 discovery");
        issue(T0, 32'h5, 5, 1'b0, "R4 table entry 0");
        issue(T1, 32'h3, 3, 1'b0, "R4 first of duplicates");
        issue(T0, 32'hFFFC_0004, 4, 1'b0, "R5 upper length bits ignored");
        issue(T1, 32'h0000_0000, 19'h40000, 1'b0, "R6 zero length max");
        issue(T1, 32'hABC0_0000, 19'h3FFFF, 1'b0, "R6 zero length short");
        issue(DISC, 32'h4, 3, 1'b0, "R7 length mismatch");
        issue(32'h0001_0001, 32'h2, 2, 1'b0, "R8 unknown header");
        issue(DISC, 32'h2, 2, 1'b1, "R9 error blocks go");
        issue(DISC, 32'h2, 2, 1'b0, "R2 dispatch after error");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [LB:0] c;
            case ($urandom_range(0, 4))
                0: a = DISC;
                1: a = T0;
                2: a = T1;
                3: a = 32'h0004_1E98;
                default: a = $urandom;
            endcase
            b = {$urandom_range(0, 16383), 18'h0} | $urandom_range(0, 9);
            case ($urandom_range(0, 3))
                0: c = exp_len(b) - 1;
                1: c = exp_len(b) + 1;
                default: c = exp_len(b);
            endcase
            issue(a, b, c, ($urandom_range(0, 7) == 0), "R2 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule